// File: doc/BRIEF.md
# Converter Host Control and Readout Logic

This block sits between a host bus and a 12-bit successive-approximation conversion engine. It watches a chip enable (`chip_en`), an active-low chip select (`chip_sel_n`), a read/convert line (`read_conv_n`, low = convert, high = read), an address bit (`addr_lsb`) and a width select (`wide_sel`). It issues a one-cycle start strobe and a short-conversion flag to the engine, and drives a status line `sts` that stays high while a conversion runs. The engine is modelled by a `conv_done` pulse that carries `conv_result`. On the read side the block drives a 12-bit bus as a data vector plus one output enable per 4-bit nibble. In narrow mode it presents the result as two bytes: a high byte and a padded low byte.

All five host inputs pass through two-flop synchronizers, so a change at the pins reaches the outputs on the third rising clock edge. A conversion starts on the rising edge of the combined term `chip_en & !chip_sel_n & !read_conv_n`. Whichever input completes the term last therefore fires the start, and two or three inputs may change together. Holding the term high does not start another conversion. For stand-alone use, tie `chip_en` and `wide_sel` high and `chip_sel_n` and `addr_lsb` low. A low level on `read_conv_n` then converts, and a high level reads.

The conversion FSM has two states. `CV_IDLE` moves to `CV_RUN` on a start edge (transition *launch*). `CV_RUN` returns to `CV_IDLE` on `conv_done` (transition *finish*). The read FSM has five states: `RD_OFF`, `RD_FULL`, `RD_HIGH`, `RD_LOW` and `RD_GAP`. The *open* transition goes from `RD_OFF` or `RD_GAP` to the requested view. The *close* transition goes from any view to `RD_OFF` when the read condition drops. The *swap* transition goes from one enabled view to a different one through `RD_GAP`.

Top module: `adc_bus_ctrl`

## Requirements
- R1: `start_pulse` is high for exactly one cycle, the third rising edge after the start term (chip_en=1, chip_sel_n=0, read_conv_n=0) becomes true. It works whichever input completed the term, including simultaneous changes. A term that stays true does not fire again.
- R2: At the start edge `addr_lsb` is captured. `len_short` shows the captured value (0 = 12-bit conversion, 1 = 8-bit conversion) and stays unchanged while `sts` is high, whatever `addr_lsb` does.
- R3: `sts` rises on the edge after `start_pulse`. It stays high until the edge after `conv_done` is seen, then drops.
- R4: A start term edge while `sts` is high issues no `start_pulse` and does not shorten or restart the running conversion.
- R5: `bus_oe` is all zero unless read_conv_n=1, sts=0, chip_en=1 and chip_sel_n=0.
- R6: With wide_sel=1 and a read allowed, `bus_oe`=3'b111 and `bus_data` equals the stored result, whatever `addr_lsb` is.
- R7: With wide_sel=0, addr_lsb=0 and a read allowed, `bus_oe`=3'b110 (nibbles for bits 11:4) and `bus_data`={result[11:4],4'h0}.
- R8: With wide_sel=0, addr_lsb=1 and a read allowed, `bus_oe`=3'b011. Bits 7:4 are enabled and driven low, bits 3:0 carry result[3:0], and bits 11:8 are disabled.
- R9: A switch between the high-byte view (3'b110) and the low-byte view (3'b011) always passes through one cycle with `bus_oe`=0.
- R10: Any nibble whose enable is low drives zeros. After reset `sts`, `start_pulse`, `bus_oe` and `bus_data` are all zero.
- R11: `conv_result` is stored on the cycle `conv_done` arrives during a conversion. Reads return that value until the next conversion finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| chip_en | input | 1 | Chip enable, active high, asynchronous |
| chip_sel_n | input | 1 | Chip select, active low, asynchronous |
| read_conv_n | input | 1 | High = read, low = convert, asynchronous |
| addr_lsb | input | 1 | Length select at start, byte select on read |
| wide_sel | input | 1 | 1 = full 12-bit read, 0 = two-byte read |
| conv_done | input | 1 | Engine finished pulse |
| conv_result | input | 12 | Engine result, valid with conv_done |
| start_pulse | output | 1 | One-cycle conversion start strobe |
| len_short | output | 1 | Captured length flag, 1 = 8-bit conversion |
| sts | output | 1 | High while a conversion is in progress |
| bus_oe | output | 3 | Output enable per nibble, bit i covers data bits 4i+3:4i |
| bus_data | output | 12 | Data presented on the bus |

## Verification
The hardest state to reach is a second start edge that arrives while a conversion is already running. The start term must first drop and then return, all within the engine's busy window. The bench gets there by raising and lowering `read_conv_n` while the bench's engine model holds `conv_done` back for a fixed number of cycles. It then confirms that no extra start was counted and that `sts` held. The swap through `RD_GAP` is checked by toggling `addr_lsb` during a byte-mode read and sampling every cycle around the third edge. The output decode is swept over every input combination that does not itself start a conversion.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    typedef enum logic [0:0] {
        CV_IDLE = 1'b0,
        CV_RUN  = 1'b1
    } cv_state_t;

    typedef enum logic [2:0] {
        RD_OFF  = 3'd0,
        RD_FULL = 3'd1,
        RD_HIGH = 3'd2,
        RD_LOW  = 3'd3,
        RD_GAP  = 3'd4
    } rd_state_t;

    // bit positions inside the synchronized control vector
    localparam int CTL_CE   = 0;
    localparam int CTL_CSN  = 1;
    localparam int CTL_RC   = 2;
    localparam int CTL_AO   = 3;
    localparam int CTL_WIDE = 4;
    localparam int CTL_W    = 5;

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int          WIDTH   = 5,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain <= {STAGES{RST_VAL[b]}};
                else
                    chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
    import adc_bus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s,
    input  logic csn_s,
    input  logic rc_s,
    input  logic ao_s,
    input  logic conv_done,
    output logic start_pulse,
    output logic len_short,
    output logic busy
);

    cv_state_t state, nxt;
    logic      term, term_q, start_edge, ao_lat;

    assign term       = ce_s & ~csn_s & ~rc_s;
    assign start_edge = term & ~term_q;

    // remember the previous term so a held level cannot retrigger
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) term_q <= 1'b0;
        else        term_q <= term;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            CV_IDLE: if (start_edge) nxt = CV_RUN;   // launch
            CV_RUN:  if (conv_done)  nxt = CV_IDLE;  // finish
            default: nxt = CV_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CV_IDLE;
        else        state <= nxt;
    end

    // length capture, only on a start accepted in idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ao_lat <= 1'b0;
        else if (state == CV_IDLE && start_edge)
            ao_lat <= ao_s;
    end

    // outputs
    always_comb begin
        start_pulse = 1'b0;
        busy        = 1'b0;
        unique case (state)
            CV_IDLE: start_pulse = start_edge;
            CV_RUN:  busy        = 1'b1;
            default: ;
        endcase
    end

    assign len_short = ao_lat;

endmodule

// File: rtl/adc_read_ctl.sv
module adc_read_ctl
    import adc_bus_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NIB_W  = 4,
    localparam int NIBS  = DATA_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_ok,
    input  logic              wide,
    input  logic              ao,
    input  logic [DATA_W-1:0] result,
    output logic [NIBS-1:0]   oe,
    output logic [DATA_W-1:0] data
);

    rd_state_t state, nxt, want;

    // view requested by the synchronized inputs
    always_comb begin
        if (!read_ok)  want = RD_OFF;
        else if (wide) want = RD_FULL;
        else if (ao)   want = RD_LOW;
        else           want = RD_HIGH;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RD_OFF, RD_GAP: nxt = want;                       // open
            RD_FULL, RD_HIGH, RD_LOW: begin
                if (want == state || want == RD_OFF)
                    nxt = want;                               // hold / close
                else
                    nxt = RD_GAP;                             // swap
            end
            default: nxt = RD_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_OFF;
        else        state <= nxt;
    end

    // outputs, one decode per nibble
    genvar i;
    generate
        for (i = 0; i < NIBS; i++) begin : g_nib
            always_comb begin
                oe[i]                  = 1'b0;
                data[i*NIB_W +: NIB_W] = '0;
                unique case (state)
                    RD_FULL: begin
                        oe[i]                  = 1'b1;
                        data[i*NIB_W +: NIB_W] = result[i*NIB_W +: NIB_W];
                    end
                    RD_HIGH: begin
                        if (i >= NIBS - 2) begin
                            oe[i]                  = 1'b1;
                            data[i*NIB_W +: NIB_W] = result[i*NIB_W +: NIB_W];
                        end
                    end
                    RD_LOW: begin
                        if (i <= NIBS - 2) begin
                            oe[i] = 1'b1;
                            if (i == 0)
                                data[i*NIB_W +: NIB_W] = result[i*NIB_W +: NIB_W];
                        end
                    end
                    RD_OFF, RD_GAP: ;
                    default: ;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NIBS       = DATA_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              chip_sel_n,
    input  logic              read_conv_n,
    input  logic              addr_lsb,
    input  logic              wide_sel,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              start_pulse,
    output logic              len_short,
    output logic              sts,
    output logic [NIBS-1:0]   bus_oe,
    output logic [DATA_W-1:0] bus_data
);

    // idle levels: deselected, read side
    localparam logic [CTL_W-1:0] CTL_RST =
        (CTL_W'(1) << CTL_CSN) | (CTL_W'(1) << CTL_RC);

    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic [DATA_W-1:0] result_q;
    logic              read_ok;

    assign ctl_raw[CTL_CE]   = chip_en;
    assign ctl_raw[CTL_CSN]  = chip_sel_n;
    assign ctl_raw[CTL_RC]   = read_conv_n;
    assign ctl_raw[CTL_AO]   = addr_lsb;
    assign ctl_raw[CTL_WIDE] = wide_sel;

    adc_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    adc_conv_ctl u_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_s        (ctl_s[CTL_CE]),
        .csn_s       (ctl_s[CTL_CSN]),
        .rc_s        (ctl_s[CTL_RC]),
        .ao_s        (ctl_s[CTL_AO]),
        .conv_done   (conv_done),
        .start_pulse (start_pulse),
        .len_short   (len_short),
        .busy        (sts)
    );

    // hold the engine result until the next conversion finishes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            result_q <= '0;
        else if (sts && conv_done)
            result_q <= conv_result;
    end

    assign read_ok = ctl_s[CTL_RC] & ~sts & ctl_s[CTL_CE] & ~ctl_s[CTL_CSN];

    adc_read_ctl #(
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .read_ok (read_ok),
        .wide    (ctl_s[CTL_WIDE]),
        .ao      (ctl_s[CTL_AO]),
        .result  (result_q),
        .oe      (bus_oe),
        .data    (bus_data)
    );

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
    parameter int DATA_W = 12,
    parameter int NIB_W  = 4,
    localparam int NIBS  = DATA_W / NIB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic              start_pulse,
    input logic              len_short,
    input logic              sts,
    input logic [NIBS-1:0]   bus_oe,
    input logic [DATA_W-1:0] bus_data
);

    localparam logic [NIBS-1:0] HI_VIEW = {2'b11, {(NIBS-2){1'b0}}};
    localparam logic [NIBS-1:0] LO_VIEW = {1'b0, {(NIBS-1){1'b1}}};

    // R1: a start is a single-cycle strobe
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R2: captured length stays put during a conversion
    a_r2_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !conv_done) |=> $stable(len_short));

    // R3: status follows the start strobe and the done pulse
    a_r3_sts_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(start_pulse));
    a_r3_sts_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts) |-> $past(conv_done));
    a_r3_sts_launch: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> sts);

    // R4: no start strobe while a conversion runs
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sts |-> !start_pulse);

    // R5: bus stays off while busy
    a_r5_off_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sts |-> (bus_oe == '0));

    // R8: low byte pads its middle nibble with zeros
    a_r8_low_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == LO_VIEW) |-> (bus_data[NIB_W +: NIB_W] == '0));

    // R9: byte views never follow each other directly
    a_r9_hi_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == HI_VIEW) |=> (bus_oe != LO_VIEW));
    a_r9_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == LO_VIEW) |=> (bus_oe != HI_VIEW));

    // R10: disabled nibbles drive zero
    genvar i;
    generate
        for (i = 0; i < NIBS; i++) begin : g_off
            a_r10_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !bus_oe[i] |-> (bus_data[i*NIB_W +: NIB_W] == '0));
        end
    endgenerate

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(
    .DATA_W (DATA_W),
    .NIB_W  (NIB_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .start_pulse (start_pulse),
    .len_short   (len_short),
    .sts         (sts),
    .bus_oe      (bus_oe),
    .bus_data    (bus_data)
);

// File: tb/tb_adc_bus_ctrl.sv
module tb_adc_bus_ctrl;

    localparam int ENG_CYC = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0, cs_n = 1'b1, rc = 1'b1, ao = 1'b0, wide = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        start_pulse, len_short, sts;
    logic [2:0]  bus_oe;
    logic [11:0] bus_data;

    int          n_chk = 0, n_bad = 0, starts = 0, conv_k = 0;
    logic [11:0] last_res = '0;

    always #10 clk = ~clk;

    adc_bus_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_en     (ce),
        .chip_sel_n  (cs_n),
        .read_conv_n (rc),
        .addr_lsb    (ao),
        .wide_sel    (wide),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .start_pulse (start_pulse),
        .len_short   (len_short),
        .sts         (sts),
        .bus_oe      (bus_oe),
        .bus_data    (bus_data)
    );

    // strobe counter
    initial forever begin
        @(negedge clk);
        if (start_pulse) starts++;
    end

    // engine model: fixed latency, then a one-cycle done pulse
    initial forever begin
        @(negedge clk);
        if (start_pulse) begin
            repeat (ENG_CYC) @(negedge clk);
            conv_k++;
            conv_result = 12'((conv_k * 12'h3A5) ^ 12'hC3C);
            last_res    = conv_result;
            conv_done   = 1'b1;
            @(negedge clk);
            conv_done   = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic s, input logic r, input logic a, input logic w);
        @(negedge clk);
        ce = c; cs_n = s; rc = r; ao = a; wide = w;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (sts) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [2:0] e_oe(input logic c, input logic s, input logic r,
                                        input logic a, input logic w);
        if (!(c && !s && r)) return 3'b000;
        if (w) return 3'b111;
        if (a) return 3'b011;
        return 3'b110;
    endfunction

    function automatic logic [11:0] e_dat(input logic [2:0] oe, input logic [11:0] res);
        case (oe)
            3'b111:  return res;
            3'b011:  return {8'h00, res[3:0]};
            3'b110:  return {res[11:4], 4'h0};
            default: return 12'h000;
        endcase
    endfunction

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 sts", sts, 0);
        chk("R10 start", start_pulse, 0);
        chk("R10 oe", bus_oe, 0);
        chk("R10 data", bus_data, 0);

        // R1: read_conv_n completes the term, 12-bit length
        drive(1, 0, 1, 0, 1);
        settle();
        chk("R1 no start yet", starts, 0);
        drive(1, 0, 0, 0, 1);
        settle();
        chk("R1 start by read_conv_n", starts, 1);
        chk("R3 sts high", sts, 1);
        chk("R2 len 12-bit", len_short, 0);
        drive(1, 0, 0, 1, 1);
        settle();
        chk("R2 len held", len_short, 0);
        // R4 and R5: new term edge while busy
        drive(1, 0, 1, 1, 1);
        settle();
        chk("R5 off while busy", bus_oe, 0);
        drive(1, 0, 0, 1, 1);
        settle();
        chk("R4 no restart", starts, 1);
        chk("R4 sts kept", sts, 1);
        wait_idle();
        repeat (8) @(negedge clk);
        chk("R1 held level", starts, 1);
        chk("R3 sts low", sts, 0);
        drive(1, 0, 1, 0, 1);
        settle();
        chk("R6 wide oe", bus_oe, 3'b111);
        chk("R11 result", bus_data, last_res);

        // R1: chip_sel_n completes the term, 8-bit length
        drive(1, 1, 0, 1, 0);
        settle();
        chk("R1 no start cs high", starts, 1);
        drive(1, 0, 0, 1, 0);
        settle();
        chk("R1 start by chip_sel_n", starts, 2);
        chk("R2 len 8-bit", len_short, 1);
        wait_idle();

        // R1: chip_en completes the term
        drive(0, 0, 0, 0, 0);
        settle();
        drive(1, 0, 0, 0, 0);
        settle();
        chk("R1 start by chip_en", starts, 3);
        chk("R2 len 12-bit again", len_short, 0);
        wait_idle();

        // R1: all three together
        drive(0, 1, 1, 1, 1);
        settle();
        drive(1, 0, 0, 1, 1);
        settle();
        chk("R1 simultaneous", starts, 4);
        chk("R2 len simultaneous", len_short, 1);
        wait_idle();
        drive(1, 0, 1, 0, 1);
        settle();
        chk("R11 second result", bus_data, last_res);

        // output decode sweep
        s0 = starts;
        for (int i = 0; i < 32; i++) begin
            logic c, s, r, a, w;
            logic [2:0] eo;
            string tag;
            c = i[0]; s = i[1]; r = i[2]; a = i[3]; w = i[4];
            if (c && !s && !r) continue;
            drive(0, 1, 1, 0, 0);
            repeat (4) @(negedge clk);
            drive(c, s, r, a, w);
            settle();
            eo = e_oe(c, s, r, a, w);
            if (eo == 3'b000)      tag = "R5";
            else if (eo == 3'b111) tag = "R6";
            else if (eo == 3'b011) tag = "R8";
            else                   tag = "R7";
            chk({tag, " oe"}, bus_oe, eo);
            chk({tag, " R10 data"}, bus_data, e_dat(eo, last_res));
        end
        chk("R1 sweep no start", starts, s0);

        // R9: byte swap passes through an all-off cycle
        drive(1, 0, 1, 0, 0);
        settle();
        chk("R7 high view", bus_oe, 3'b110);
        drive(1, 0, 1, 1, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 gap hi->lo", bus_oe, 3'b000);
        @(negedge clk);
        chk("R8 low view", bus_oe, 3'b011);
        chk("R8 low data", bus_data, {8'h00, last_res[3:0]});
        drive(1, 0, 1, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 gap lo->hi", bus_oe, 3'b000);
        @(negedge clk);
        chk("R7 high data", bus_data, {last_res[11:4], 4'h0});

        summary();
        $finish;
    end

endmodule